// File: doc/BRIEF.md
# Mailbox receive FIFO

This block is the receive half of an inter-processor mailbox. Remote cores deliver messages through a simple push port. Each message is a 64-bit payload tagged with the channel number of its sender. Messages collect in a circular queue. The local processor sees the oldest entry through a small register window and removes it with a trigger write.

Software learns how full the queue is from one status word. That word holds the raw read index, the raw write index and a full flag. When the two indexes are equal, the flag tells a full queue from an empty one. A depth register reads back the queue size minus one. With these three values software can compute the number of waiting messages without a separate counter.

A sticky interrupt status bit sets while any message is waiting and is cleared by a write of one. An interrupt mask gates it onto the interrupt line. A write of zero to the reset register empties the queue at once.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0, the mask register (offset 0x1C) reads 0x1F, the interrupt status (offset 0x18) reads 0 and `irqOut` is low.
- R2: A push while the queue is not full stores the message and its channel in the slot at the write index, and advances that index modulo DEPTH. The head entry reads as follows: payload bits [31:0] at offset 0x04, payload bits [63:32] at offset 0x08, and the zero-extended channel at offset 0x00.
- R3: A write to offset 0x0C with bit 0 set removes the head entry and advances the read index modulo DEPTH. Entries leave in the order they were pushed.
- R4: The status word at offset 0x14 carries the read index in bits [31:24] and the write index in bits [23:16], each zero-extended to 8 bits, and the full flag in bit 2. All other bits read 0.
- R5: The full flag sets when a push makes the write index equal to the read index, and clears on the next removal. Equal indexes with the flag clear mean the queue is empty. Software's level formula gives the number of waiting entries: write index minus read index when the write index is larger, DEPTH minus read index plus write index when it is smaller, and DEPTH or 0 when they are equal.
- R6: A push while the queue is full is dropped. Both indexes, the flag and the head entry stay unchanged.
- R7: A removal trigger while the queue is empty has no effect. A write to offset 0x0C with bit 0 clear has no effect.
- R8: Offset 0x24 reads DEPTH-1.
- R9: Interrupt status bit 0 at offset 0x18 sets in the cycle after the queue is seen non-empty and holds until a write with bit 0 set to offset 0x18 clears it. If entries remain after the clear, it sets again one cycle later.
- R10: The mask register keeps bits [4:0] of what is written to it, and its upper bits read 0. `irqOut` is high exactly when the interrupt status is set and mask bit 0 is 0.
- R11: A write of 0 to offset 0x10 sets both indexes to 0 and clears the full flag. A nonzero write to that offset has no effect.
- R12: A push and a removal in the same cycle, with the queue neither empty nor full, both take effect and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| pushValid | input | 1 | Push strobe from the remote side |
| pushMsg | input | 2*WORD_W | Message payload to push |
| pushChan | input | CHAN_W | Source channel of the pushed message |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | WORD_W | Register write data |
| regRdData | output | WORD_W | Register read data, combinational from regAddr |
| irqOut | output | 1 | Not-empty interrupt after masking |

## Verification
The bench fills and drains the queue with three payload patterns. Incrementing values expose ordering and index mistakes. A walking single one tells the low word from the high word and catches swapped or shifted bits. Alternating ones and zeros with full-width channel values catch stuck or truncated bits. The queue is run through index wrap-around, full and overfilled states, and empty triggers. Every status read is also decoded with the software level formula and compared with the scoreboard's occupancy, so the raw index and full-flag encoding is checked as software would use it.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;

  // Register byte offsets; software depends on these values.
  localparam int unsigned OFF_CHAN  = 'h00;
  localparam int unsigned OFF_LOW   = 'h04;
  localparam int unsigned OFF_HIGH  = 'h08;
  localparam int unsigned OFF_TRIG  = 'h0C;
  localparam int unsigned OFF_RST   = 'h10;
  localparam int unsigned OFF_STAT  = 'h14;
  localparam int unsigned OFF_ISTS  = 'h18;
  localparam int unsigned OFF_MASK  = 'h1C;
  localparam int unsigned OFF_DEPTH = 'h24;

  // Status word field positions.
  localparam int unsigned STAT_RD_LSB = 24;
  localparam int unsigned STAT_WR_LSB = 16;
  localparam int unsigned STAT_FULL   = 2;
  localparam int unsigned PTR_FIELD_W = 8;

  // Strobes from control to datapath.
  typedef struct packed {
    logic pop;
    logic flush;
  } dpStrobe_t;

endpackage

// File: rtl/mbox_rx_store.sv
module mbox_rx_store
  import mbox_rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned MSG_W  = 64,
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [MSG_W-1:0]  pushMsg,
  input  logic [CHAN_W-1:0] pushChan,
  input  dpStrobe_t         strb,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              full,
  output logic              empty,
  output logic [MSG_W-1:0]  headMsg,
  output logic [CHAN_W-1:0] headChan
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [MSG_W-1:0]  msgMem  [DEPTH];
  logic [CHAN_W-1:0] chanMem [DEPTH];

  logic             pushOk, popOk;
  logic [IDX_W-1:0] wrNext, rdNext;

  function automatic logic [IDX_W-1:0] bumpIdx(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  assign empty  = (rdIdx == wrIdx) && !full;
  assign pushOk = pushValid && !full && !strb.flush;
  assign popOk  = strb.pop && !empty && !strb.flush;
  assign wrNext = bumpIdx(wrIdx);
  assign rdNext = bumpIdx(rdIdx);

  always_ff @(posedge clk) begin
    if (pushOk) begin
      msgMem[wrIdx]  <= pushMsg;
      chanMem[wrIdx] <= pushChan;
    end
  end

  assign headMsg  = msgMem[rdIdx];
  assign headChan = chanMem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      rdIdx <= '0;
      wrIdx <= '0;
      full  <= 1'b0;
    end else begin
      if (pushOk) wrIdx <= wrNext;
      if (popOk)  rdIdx <= rdNext;
      if (pushOk && !popOk && (wrNext == rdIdx)) full <= 1'b1;
      else if (popOk && !pushOk)                 full <= 1'b0;
    end
  end

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full && !strb.pop && !strb.flush) |=> (full && $stable(wrIdx) && $stable(rdIdx)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && empty && !pushValid && !strb.flush) |=> ($stable(rdIdx) && $stable(wrIdx) && !full));

  // R5
  full_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (rdIdx == wrIdx));

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (rdIdx == '0 && wrIdx == '0 && !full));

  // R12
  both_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && strb.pop && !full && !empty && !strb.flush) |=> ($past(wrIdx) != wrIdx && $past(rdIdx) != rdIdx && !full));

endmodule

// File: rtl/mbox_rx_ctrl.sv
module mbox_rx_ctrl
  import mbox_rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned MASK_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [IDX_W-1:0]    rdIdx,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                full,
  input  logic                empty,
  input  logic [2*WORD_W-1:0] headMsg,
  input  logic [CHAN_W-1:0]   headChan,
  output logic [WORD_W-1:0]   regRdData,
  output dpStrobe_t           strb,
  output logic                irqOut
);

  logic [MASK_W-1:0] maskReg;
  logic              irqSts;
  logic              clrIrq, maskWr;
  logic [WORD_W-1:0] statWord;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  assign strb.pop   = regWrEn && hit(regAddr, OFF_TRIG) && regWrData[0];
  assign strb.flush = regWrEn && hit(regAddr, OFF_RST) && (regWrData == '0);
  assign clrIrq     = regWrEn && hit(regAddr, OFF_ISTS) && regWrData[0];
  assign maskWr     = regWrEn && hit(regAddr, OFF_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '1;
      irqSts  <= 1'b0;
    end else begin
      if (maskWr) maskReg <= regWrData[MASK_W-1:0];
      if (clrIrq) irqSts  <= 1'b0;
      else if (!empty) irqSts <= 1'b1;
    end
  end

  assign irqOut = irqSts && !maskReg[0];

  always_comb begin
    statWord = '0;
    statWord[STAT_RD_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(rdIdx);
    statWord[STAT_WR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(wrIdx);
    statWord[STAT_FULL] = full;
  end

  always_comb begin
    regRdData = '0;
    if (hit(regAddr, OFF_CHAN))       regRdData = WORD_W'(headChan);
    else if (hit(regAddr, OFF_LOW))   regRdData = headMsg[WORD_W-1:0];
    else if (hit(regAddr, OFF_HIGH))  regRdData = headMsg[2*WORD_W-1:WORD_W];
    else if (hit(regAddr, OFF_STAT))  regRdData = statWord;
    else if (hit(regAddr, OFF_ISTS))  regRdData = WORD_W'(irqSts);
    else if (hit(regAddr, OFF_MASK))  regRdData = WORD_W'(maskReg);
    else if (hit(regAddr, OFF_DEPTH)) regRdData = WORD_W'(DEPTH - 1);
  end

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !clrIrq) |=> irqSts);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrIrq |=> !irqSts);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && regWrData[0]) |=> !irqOut);

endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CHAN_W = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [2*WORD_W-1:0] pushMsg,
  input  logic [CHAN_W-1:0]   pushChan,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [WORD_W-1:0]   regWrData,
  output logic [WORD_W-1:0]   regRdData,
  output logic                irqOut
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned MSG_W = 2 * WORD_W;

  dpStrobe_t         strb;
  logic [IDX_W-1:0]  rdIdx, wrIdx;
  logic              full, empty;
  logic [MSG_W-1:0]  headMsg;
  logic [CHAN_W-1:0] headChan;

  mbox_rx_store #(
    .DEPTH(DEPTH), .MSG_W(MSG_W), .CHAN_W(CHAN_W), .IDX_W(IDX_W)
  ) i_store (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushMsg(pushMsg), .pushChan(pushChan),
    .strb(strb),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .full(full), .empty(empty),
    .headMsg(headMsg), .headChan(headChan)
  );

  mbox_rx_ctrl #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .CHAN_W(CHAN_W),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MASK_W(5)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .rdIdx(rdIdx), .wrIdx(wrIdx), .full(full), .empty(empty),
    .headMsg(headMsg), .headChan(headChan),
    .regRdData(regRdData), .strb(strb), .irqOut(irqOut)
  );

endmodule

// File: tb/test_mbox_rx_fifo.sv
`timescale 1ns/1ps
module test_mbox_rx_fifo;

  localparam int DEPTH  = 8;
  localparam int CHAN_W = 3;

  logic        clk = 0;
  logic        rstN = 0;
  logic        pushValid = 0;
  logic [63:0] pushMsg = '0;
  logic [CHAN_W-1:0] pushChan = '0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  always #2.5 clk = ~clk;

  mbox_rx_fifo #(.DEPTH(DEPTH), .WORD_W(32), .CHAN_W(CHAN_W), .ADDR_W(6)) i_mbox_rx_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushMsg(pushMsg), .pushChan(pushChan),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [63+CHAN_W:0] sbq[$];
  int mRd = 0;
  int mWr = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // driver: pushes and records the expected entry
  task automatic doPush(input logic [63:0] m, input logic [CHAN_W-1:0] c);
    @(negedge clk);
    pushValid = 1; pushMsg = m; pushChan = c;
    @(negedge clk);
    pushValid = 0;
    if (sbq.size() < DEPTH) begin
      sbq.push_back({c, m});
      mWr = (mWr + 1) % DEPTH;
    end
  endtask

  task automatic checkStatus(input string req);
    logic [31:0] s;
    int lvl, r, w;
    logic expFull;
    expFull = (sbq.size() == DEPTH);
    regRead(6'h14, s);
    check(req, s, {8'(mRd), 8'(mWr), 13'b0, expFull, 2'b0});
    r = int'(s[31:24]); w = int'(s[23:16]);
    if (w == r) lvl = s[2] ? DEPTH : 0;
    else if (w > r) lvl = w - r;
    else lvl = DEPTH - r + w;
    check({req, " level"}, 32'(lvl), 32'(sbq.size()));
  endtask

  // monitor: compares the head against the scoreboard, then removes it
  task automatic popCheck(input string req);
    logic [31:0] lo, hi, ch;
    logic [63+CHAN_W:0] e;
    e = sbq[0];
    regRead(6'h00, ch);
    regRead(6'h04, lo);
    regRead(6'h08, hi);
    check({req, " chan"}, ch, 32'(e[63+CHAN_W:64]));
    check({req, " low"}, lo, e[31:0]);
    check({req, " high"}, hi, e[63:32]);
    regWrite(6'h0C, 32'h1);
    void'(sbq.pop_front());
    mRd = (mRd + 1) % DEPTH;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 / R8 reset state
    regRead(6'h14, d); check("R1 status", d, 32'h0);
    regRead(6'h1C, d); check("R1 mask", d, 32'h1F);
    regRead(6'h18, d); check("R1 irqsts", d, 32'h0);
    check("R1 irqOut", 32'(irqOut), 32'h0);
    regRead(6'h24, d); check("R8 depth", d, 32'(DEPTH - 1));

    // R2 incrementing pattern
    for (int i = 0; i < 3; i++)
      doPush({32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)}, CHAN_W'(i + 1));
    checkStatus("R4 after 3 pushes");
    regRead(6'h18, d); check("R9 sts set", d, 32'h1);
    check("R10 masked", 32'(irqOut), 32'h0);

    // R10 mask behaviour
    regWrite(6'h1C, 32'h0);
    check("R10 unmasked", 32'(irqOut), 32'h1);
    regWrite(6'h1C, 32'hFFFF_FFFF);
    regRead(6'h1C, d); check("R10 mask bits", d, 32'h1F);
    check("R10 remasked", 32'(irqOut), 32'h0);
    regWrite(6'h1C, 32'h0);

    // R3 drain in order
    for (int i = 0; i < 3; i++) popCheck("R3 order");
    checkStatus("R5 empty");

    // R9 clear on empty stays clear
    regWrite(6'h18, 32'h1);
    @(negedge clk);
    regRead(6'h18, d); check("R9 stays clear", d, 32'h0);
    check("R10 irq low", 32'(irqOut), 32'h0);

    // R7 pop on empty, trigger with bit0 clear
    regWrite(6'h0C, 32'h1);
    checkStatus("R7 empty pop");
    doPush(64'h1234_5678_9ABC_DEF0, CHAN_W'(5));
    regWrite(6'h0C, 32'h2);
    checkStatus("R7 bit0 clear");
    popCheck("R7 head intact");

    // R5 walking one fill across wrap
    for (int i = 0; i < DEPTH; i++)
      doPush(64'h1 << (i * 9), CHAN_W'(i));
    checkStatus("R5 full");
    // R6 overfill dropped
    doPush(64'hDEAD_BEEF_DEAD_BEEF, CHAN_W'(7));
    checkStatus("R6 drop");
    popCheck("R6 head");
    checkStatus("R5 full clears");

    // R12 simultaneous push and pop
    begin
      logic [63:0] m;
      m = 64'hAAAA_5555_AAAA_5555;
      @(negedge clk);
      pushValid = 1; pushMsg = m; pushChan = '1;
      regAddr = 6'h0C; regWrData = 32'h1; regWrEn = 1;
      @(negedge clk);
      pushValid = 0; regWrEn = 0;
      void'(sbq.pop_front());
      mRd = (mRd + 1) % DEPTH;
      sbq.push_back({CHAN_W'('1), m});
      mWr = (mWr + 1) % DEPTH;
      checkStatus("R12 both");
    end

    // R9 clear while non-empty re-sets next cycle
    regWrite(6'h18, 32'h1);
    regRead(6'h18, d); check("R9 cleared", d, 32'h0);
    @(negedge clk);
    regRead(6'h18, d); check("R9 re-set", d, 32'h1);
    check("R10 irq high", 32'(irqOut), 32'h1);

    // R11 flush
    regWrite(6'h10, 32'h5);
    checkStatus("R11 nonzero ignored");
    popCheck("R11 content kept");
    regWrite(6'h10, 32'h0);
    sbq.delete(); mRd = 0; mWr = 0;
    checkStatus("R11 flushed");

    // R2 alternating pattern after flush
    doPush(64'h5555_5555_AAAA_AAAA, CHAN_W'(2));
    doPush(64'hFFFF_0000_0000_FFFF, CHAN_W'(7));
    checkStatus("R2 refill");
    popCheck("R2 alt");
    popCheck("R2 alt");
    checkStatus("R3 drained");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule